// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transmitter

This block serialises bytes onto a single transmit line. Each frame has a start bit, the data bits, an optional parity bit and one or two stop bits. It has two stages. A one-byte holding register is loaded from a bus write port. A frame shifter behind it drives the line. Software or a DMA engine writes a byte and then pulses a clear strobe to drop the "holding register empty" flag. On the next baud tick where the shifter can accept work, the byte moves into the shifter and the empty flag rises again. This invites the next byte while the current frame is still on the line.

If the next byte is pending when the last stop bit ends, its start bit follows on that same tick, so consecutive frames have no idle gap. If nothing is pending, a separate transmit-end flag rises and the line returns to the marking level. Both flags drive level interrupt requests, each masked by its own enable. Baud timing comes from outside as a one-cycle tick per bit period.

Top module: `sio_tx`

## Requirements
- R1: A frame is sent least significant bit first, as follows: a start bit of 0, then the data bits, then the parity bit if enabled, then the stop bits, each at 1.
- R2: When no frame is being shifted, txd_o is 1.
- R3: The holding register is transferred into the shifter on the first baud tick after the empty flag is cleared while the shifter is idle. On that same tick the start bit appears and empty_o returns to 1.
- R4: A byte whose clear strobe comes before the final stop bit ends starts on the tick that ends that stop bit. No idle bit is inserted and end_o stays 0.
- R5: If empty_o is 1 on the tick that ends the final stop bit, end_o becomes 1 and txd_o returns to 1.
- R6: The clear strobe sets empty_o and end_o to 0 in the cycle after it is sampled, unless transmission is disabled.
- R7: txd_o changes only on a baud tick, so each bit lasts exactly one tick interval.
- R8: The configuration is sampled on the start-bit tick. cfg_short_i=1 sends wr_data_i[6:0] as 7 data bits, and cfg_short_i=0 sends 8 bits. Parity covers the data bits only. With cfg_par_odd_i=0 the data and parity bits together hold an even number of ones; with cfg_par_odd_i=1 they hold an odd number. cfg_two_stop_i=1 sends two stop bits.
- R9: irq_empty_o equals empty_o AND irq_empty_en_i. irq_end_o equals end_o AND irq_end_en_i.
- R10: While tx_en_i is 0, txd_o is 1, any frame in progress is abandoned, empty_o and end_o read 1, and the clear strobe is ignored.
- R11: A write to the holding register while a frame is being shifted does not change that frame's bits.
- R12: After reset, txd_o, empty_o and end_o are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable |
| wr_en_i | input | 1 | Write strobe for the holding register |
| wr_data_i | input | 8 | Byte to write |
| empty_clr_i | input | 1 | Strobe that clears the empty flag (data pending) |
| baud_tick_i | input | 1 | One-cycle pulse per bit period |
| cfg_short_i | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| cfg_par_en_i | input | 1 | Parity bit enable |
| cfg_par_odd_i | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop_i | input | 1 | 1 = two stop bits |
| irq_empty_en_i | input | 1 | Enable for the empty interrupt |
| irq_end_en_i | input | 1 | Enable for the transmit-end interrupt |
| txd_o | output | 1 | Serial transmit line |
| empty_o | output | 1 | Holding register empty flag |
| end_o | output | 1 | Transmit-end flag |
| irq_empty_o | output | 1 | Empty interrupt request, level |
| irq_end_o | output | 1 | Transmit-end interrupt request, level |

## Verification
The flags and the line are decoded straight from registers, so every result is due one clock edge after its cause. A clear strobe shows on empty_o and end_o one edge later, and a baud tick moves txd_o, empty_o and end_o at the edge that samples it. The bench drives each strobe for exactly one cycle between falling edges and samples at the next falling edge, once the result is due. It also samples again after extra tick-free cycles to show that a bit holds its value until the next tick.

// File: rtl/sio_tx_pkg.sv
package sio_tx_pkg;
  typedef struct packed {
    logic short_data;
    logic par_en;
    logic par_odd;
    logic two_stop;
  } tx_cfg_t;
endpackage

// File: rtl/sio_tx_frame.sv
module sio_tx_frame
  import sio_tx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int FRAME_W = DATA_W + 4,
  parameter int CNT_W   = $clog2(FRAME_W)
) (
  input  logic [DATA_W-1:0]  data_i,
  input  tx_cfg_t            cfg_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   last_o
);
  int   n_bits;
  logic par;

  always_comb begin
    n_bits = cfg_i.short_data ? DATA_W - 1 : DATA_W;
    par    = cfg_i.par_odd;
    for (int i = 0; i < DATA_W; i++)
      if (i < n_bits) par = par ^ data_i[i];
    frame_o    = '1;
    frame_o[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++)
      if (i < n_bits) frame_o[1+i] = data_i[i];
    // parity sits right after the last data bit
    if (cfg_i.par_en)
      for (int i = DATA_W - 1; i <= DATA_W; i++)
        if (i == n_bits) frame_o[1+i] = par;
    last_o = CNT_W'(n_bits + (cfg_i.par_en ? 1 : 0) + (cfg_i.two_stop ? 2 : 1));
  end
endmodule

// File: rtl/sio_tx_shifter.sv
module sio_tx_shifter #(
  parameter int FRAME_W = 12,
  parameter int CNT_W   = $clog2(FRAME_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               load_req_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [CNT_W-1:0]   last_i,
  output logic               txd_o,
  output logic               xfer_o,
  output logic               done_o
);
  logic               busy_q;
  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   left_q;
  logic               at_end;

  assign at_end = (left_q == '0);
  assign xfer_o = en_i & tick_i & load_req_i & (~busy_q | at_end);
  assign done_o = en_i & tick_i & busy_q & at_end & ~load_req_i;
  assign txd_o  = ~busy_q | sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
    end else if (tick_i) begin
      if (xfer_o) begin
        busy_q <= 1'b1;
        sh_q   <= frame_i;
        left_q <= last_i;
      end else if (busy_q) begin
        if (at_end) begin
          busy_q <= 1'b0;
        end else begin
          sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
          left_q <= left_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sio_tx_status.sv
module sio_tx_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic clr_i,
  input  logic xfer_i,
  input  logic done_i,
  output logic empty_o,
  output logic end_o
);
  logic empty_q, end_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else if (!en_i) begin
      empty_q <= 1'b1;
      end_q   <= 1'b1;
    end else begin
      if (xfer_i)     empty_q <= 1'b1;
      else if (clr_i) empty_q <= 1'b0;
      if (clr_i)       end_q <= 1'b0;
      else if (done_i) end_q <= 1'b1;
    end
  end

  assign empty_o = empty_q | ~en_i;
  assign end_o   = end_q | ~en_i;
endmodule

// File: rtl/sio_tx.sv
module sio_tx
  import sio_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              empty_clr_i,
  input  logic              baud_tick_i,
  input  logic              cfg_short_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_two_stop_i,
  input  logic              irq_empty_en_i,
  input  logic              irq_end_en_i,
  output logic              txd_o,
  output logic              empty_o,
  output logic              end_o,
  output logic              irq_empty_o,
  output logic              irq_end_o
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W);

  logic [DATA_W-1:0]  hold_q;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   last;
  logic               sh_txd, xfer, done;
  tx_cfg_t            cfg;

  assign cfg = '{short_data: cfg_short_i, par_en: cfg_par_en_i,
                 par_odd: cfg_par_odd_i, two_stop: cfg_two_stop_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hold_q <= '0;
    else if (wr_en_i) hold_q <= wr_data_i;
  end

  sio_tx_frame #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_frame (
    .data_i (hold_q),
    .cfg_i  (cfg),
    .frame_o(frame),
    .last_o (last)
  );

  sio_tx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (tx_en_i),
    .tick_i    (baud_tick_i),
    .load_req_i(~empty_o),
    .frame_i   (frame),
    .last_i    (last),
    .txd_o     (sh_txd),
    .xfer_o    (xfer),
    .done_o    (done)
  );

  sio_tx_status u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tx_en_i),
    .clr_i  (empty_clr_i),
    .xfer_i (xfer),
    .done_i (done),
    .empty_o(empty_o),
    .end_o  (end_o)
  );

  assign txd_o       = sh_txd | ~tx_en_i;
  assign irq_empty_o = empty_o & irq_empty_en_i;
  assign irq_end_o   = end_o & irq_end_en_i;
endmodule

// File: rtl/sio_tx_chk.sv
module sio_tx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_en_i,
  input logic baud_tick_i,
  input logic empty_clr_i,
  input logic txd_o,
  input logic empty_o,
  input logic end_o,
  input logic irq_empty_o,
  input logic irq_end_o
);
  p_disabled_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> (txd_o && empty_o && end_o));

  p_end_needs_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |-> empty_o);

  p_bit_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_i && $past(tx_en_i) && !$past(baud_tick_i)) |-> $stable(txd_o));

  p_empty_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(empty_o) && $past(tx_en_i)) |-> $past(baud_tick_i));

  p_end_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(end_o) |-> $past(empty_clr_i));

  p_irq_mask_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_empty_o || empty_o) && (!irq_end_o || end_o));
endmodule

bind sio_tx sio_tx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tx_en_i    (tx_en_i),
  .baud_tick_i(baud_tick_i),
  .empty_clr_i(empty_clr_i),
  .txd_o      (txd_o),
  .empty_o    (empty_o),
  .end_o      (end_o),
  .irq_empty_o(irq_empty_o),
  .irq_end_o  (irq_end_o)
);

// File: tb/sio_tx_bench.sv
module sio_tx_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_en = 1'b1, wr_en = 1'b0, clr = 1'b0, tick = 1'b0;
  logic [7:0] wr_data = '0;
  logic c_short = 1'b0, c_pe = 1'b0, c_po = 1'b0, c_ts = 1'b0;
  logic ie_empty = 1'b1, ie_end = 1'b1;
  logic txd, empty, tend, irq_e, irq_t;
  int n_chk = 0, n_err = 0;

  always #5 clk = ~clk;

  sio_tx u_sio_tx (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .empty_clr_i(clr), .baud_tick_i(tick),
    .cfg_short_i(c_short), .cfg_par_en_i(c_pe), .cfg_par_odd_i(c_po),
    .cfg_two_stop_i(c_ts), .irq_empty_en_i(ie_empty), .irq_end_en_i(ie_end),
    .txd_o(txd), .empty_o(empty), .end_o(tend),
    .irq_empty_o(irq_e), .irq_end_o(irq_t)
  );

  // {two_stop, par_odd, par_en, short, data}
  localparam int NVEC = 8;
  localparam logic [11:0] VEC [NVEC] = '{
    12'h0_A5, 12'h0_01, 12'h2_C3, 12'h6_C3,
    12'h8_7E, 12'h1_FF, 12'h3_80, 12'hE_5A
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input logic do_clr);
    @(negedge clk) begin wr_en = 1'b1; wr_data = d; clr = do_clr; end
    @(negedge clk) begin wr_en = 1'b0; clr = 1'b0; end
  endtask

  task automatic pulse_clr();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  function automatic void build(input logic [11:0] v, output logic [11:0] bits, output int len);
    int nb;
    logic p;
    nb = v[8] ? 7 : 8;
    p  = v[10];
    bits = '1;
    bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      bits[1+i] = v[i];
      p = p ^ v[i];
    end
    len = 1 + nb;
    if (v[9]) begin bits[len] = p; len++; end
    len += v[11] ? 2 : 1;
  endfunction

  task automatic set_cfg(input logic [11:0] v);
    c_short = v[8]; c_pe = v[9]; c_po = v[10]; c_ts = v[11];
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [11:0] bits;
    int len;
    idle(2);
    // R12 reset state, R9 masks
    chk(txd, 1, "R12 txd"); chk(empty, 1, "R12 empty"); chk(tend, 1, "R12 end");
    @(negedge clk) rst_ni = 1'b1;
    chk(irq_e, 1, "R9 irq_empty"); chk(irq_t, 1, "R9 irq_end");
    ie_empty = 1'b0; ie_end = 1'b0;
    #1 chk(irq_e, 0, "R9 irq_empty masked"); chk(irq_t, 0, "R9 irq_end masked");
    ie_empty = 1'b1; ie_end = 1'b1;

    // table walk: R1 R3 R5 R6 R7 R8
    for (int k = 0; k < NVEC; k++) begin
      set_cfg(VEC[k]);
      build(VEC[k], bits, len);
      put(VEC[k][7:0], 1'b1);
      chk(empty, 0, "R6 empty cleared"); chk(tend, 0, "R6 end cleared");
      idle(2);
      chk(txd, 1, "R2 idle before tick");
      pulse_tick();
      chk(empty, 1, "R3 empty on transfer"); chk(txd, bits[0], "R1 start bit");
      for (int b = 1; b < len; b++) begin
        idle(1);
        chk(txd, bits[b-1], "R7 bit held");
        pulse_tick();
        chk(txd, bits[b], "R1 R8 frame bit");
      end
      chk(tend, 0, "R5 end low during stop");
      pulse_tick();
      chk(txd, 1, "R5 line marking"); chk(tend, 1, "R5 end set");
      chk(irq_t, 1, "R9 irq_end");
    end

    // back-to-back with write during frame: R4 R11
    set_cfg(12'h0_00);
    build(12'h0_3C, bits, len);
    put(8'h3C, 1'b1);
    pulse_tick();
    chk(txd, 0, "R4 first start");
    put(8'hC3, 1'b0);
    for (int b = 1; b < len; b++) begin
      pulse_tick();
      chk(txd, bits[b], "R11 frame unchanged by write");
      if (b == 3) pulse_clr();
    end
    chk(empty, 0, "R4 next pending");
    pulse_tick();
    chk(txd, 0, "R4 next start without gap"); chk(tend, 0, "R4 end stays low");
    chk(empty, 1, "R4 second transfer");
    pulse_tick();
    chk(txd, 1, "R4 second frame D0 of C3");

    // disable mid-frame: R10
    @(negedge clk) tx_en = 1'b0;
    #1 chk(txd, 1, "R10 txd high"); chk(empty, 1, "R10 empty"); chk(tend, 1, "R10 end");
    pulse_clr();
    chk(empty, 1, "R10 clear ignored");
    @(negedge clk) tx_en = 1'b1;
    idle(1);
    chk(empty, 1, "R10 empty after enable");
    pulse_tick();
    chk(txd, 1, "R10 no frame resumed"); chk(tend, 1, "R10 end after enable");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule